// File: doc/BRIEF.md
# Serial Memory Command Controller

This block sits behind a serial peripheral front end that turns the shifted bit stream into whole bytes. It reads the command byte that opens each chip-select frame and collects a two-byte address. It then moves data between the serial side and a 32768 x 8 synchronous RAM. After each data byte the address steps forward by one. The block also holds a write-enable latch and a small status register. Every write reaches the array in the cycle its byte arrives, so the host never has to poll for completion and may open the next frame at once.

The front end tells the block when a frame opens (`frame_start`), when it closes (`frame_end`), and when a whole byte has been shifted in (`rx_valid` with `rx_byte`). For outgoing data, `tx_en` marks when the serial output should drive and `tx_byte` carries the byte to shift out. The front end pulses `tx_req` when it has used that byte and needs the next one. The RAM port is purely synchronous: a read address presented in one cycle gives its data in the next.

Top module: `smem_cmd_ctrl`

## Requirements
- R1: After reset the write-enable latch is clear, the status byte reads 0x00 and `tx_en` is low.
- R2: Command 0x06 sets the latch, which shows as status bit 1. Command 0x04 clears it.
- R3: With the latch clear, a 0x02 (write memory) frame or a 0x01 (write status) frame changes neither the RAM nor the status register, and `ram_we` never rises.
- R4: In a 0x02 frame the first address byte is sent first, holding address bits 14:8 in its bits 6:0, and the second holds bits 7:0. Each data byte that follows pulses `ram_we` once, at the current address, and the address then advances by one.
- R5: A 0x03 frame takes the same two address bytes. From two cycles after the second address byte, `tx_byte` holds the RAM byte at that address. Each `tx_req` pulse advances the address, and the next byte is ready two cycles later.
- R6: Bit 7 of the first address byte is ignored.
- R7: The address wraps from 0x7FFF to 0x0000 during a burst.
- R8: The latch clears at the `frame_end` of a write-memory or write-status frame that accepted at least one data byte. A write frame with no data byte leaves the latch set.
- R9: Command 0x05 drives the status byte on `tx_byte` with `tx_en` high. In a 0x01 frame the first data byte loads status bits 7:2. Bit 1 always shows the latch and bit 0 always reads 0.
- R10: While `sr_wp` is high, a 0x01 frame leaves the status register and the latch unchanged.
- R11: Only the first byte of a frame is decoded as a command. Later bytes of a 0x06 or 0x04 frame have no effect.
- R12: A frame that opens with any other byte ignores all its remaining bytes: `tx_en` stays low and `ram_we` stays low.
- R13: `tx_en` is high only in a status-read frame or during the data phase of a memory read. It is never high in the same cycle as `ram_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | One-cycle pulse: chip select became active |
| frame_end | input | 1 | One-cycle pulse: chip select became inactive |
| rx_valid | input | 1 | A whole byte has been received |
| rx_byte | input | 8 | The received byte |
| tx_req | input | 1 | Front end has used `tx_byte` and needs the next byte |
| tx_byte | output | 8 | Byte to shift out |
| tx_en | output | 1 | Serial output should be driven |
| sr_wp | input | 1 | Blocks writes to the status register |
| ram_addr | output | 15 | RAM address |
| ram_wdata | output | 8 | RAM write data |
| ram_we | output | 1 | RAM write enable |
| ram_rdata | input | 8 | RAM read data, one cycle after its address |

## Verification
The bench writes a frame with two address bytes but no data byte, and checks that the latch survives. A design that cleared the latch on every write command would lose it there. It runs a write and a read across 0x7FFF, where a counter that does not wrap, or is one bit too wide, would land outside the array. It sends a first address byte with bit 7 set and reads the data back at the masked address, which catches an address built from all 16 bits. Frames that follow a command with a second command byte, or open with an unknown byte, must leave the RAM, the latch and `tx_en` alone; a decoder that reads commands again in mid-frame would show up in those checks.

// File: rtl/smem_pkg.sv
package smem_pkg;

    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 15;
    localparam int LATCH_IX = 1;
    localparam int SR_LO    = 2;

    typedef enum logic [7:0] {
        CMD_LATCH_ON  = 8'h06,
        CMD_LATCH_OFF = 8'h04,
        CMD_SR_READ   = 8'h05,
        CMD_SR_WRITE  = 8'h01,
        CMD_MEM_READ  = 8'h03,
        CMD_MEM_WRITE = 8'h02
    } cmd_e;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_CMD,
        PH_ADR_HI,
        PH_ADR_LO,
        PH_WR_DATA,
        PH_RD_FETCH,
        PH_RD_CAPT,
        PH_RD_DATA,
        PH_SR_OUT,
        PH_SR_IN,
        PH_SKIP
    } phase_e;

    typedef struct packed {
        logic load_hi;
        logic load_lo;
        logic step;
    } addr_ctl_t;

    typedef struct packed {
        logic set_latch;
        logic clr_latch;
        logic load_bits;
    } sr_ctl_t;

    function automatic logic [DATA_W-1:0] pack_status(
        input logic [DATA_W-1:SR_LO] bits,
        input logic                  latch
    );
        return {bits, latch, 1'b0};
    endfunction

    function automatic logic is_tx_phase(input phase_e ph);
        return (ph == PH_SR_OUT) || (ph == PH_RD_DATA);
    endfunction

endpackage

// File: rtl/smem_addr_ctr.sv
module smem_addr_ctr
    import smem_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic            clk,
    input  logic            rst,
    input  addr_ctl_t       ctl,
    input  logic [AW-9:0]   hi_in,
    input  logic [7:0]      lo_in,
    output logic [AW-1:0]   addr
);
    localparam logic [AW-1:0] ONE = AW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr <= '0;
        end else if (ctl.load_hi) begin
            addr[AW-1:8] <= hi_in;
        end else if (ctl.load_lo) begin
            addr[7:0] <= lo_in;
        end else if (ctl.step) begin
            addr <= addr + ONE;
        end
    end

    // R4 R7
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        ctl.step && !ctl.load_hi && !ctl.load_lo |=> addr == $past(addr) + ONE);

endmodule

// File: rtl/smem_status.sv
module smem_status
    import smem_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  sr_ctl_t               ctl,
    input  logic [DATA_W-1:SR_LO] wbits,
    output logic                  latch,
    output logic [DATA_W-1:0]     status
);
    logic [DATA_W-1:SR_LO] bits_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            latch  <= 1'b0;
            bits_q <= '0;
        end else begin
            if (ctl.clr_latch)      latch <= 1'b0;
            else if (ctl.set_latch) latch <= 1'b1;
            if (ctl.load_bits)      bits_q <= wbits;
        end
    end

    assign status = pack_status(bits_q, latch);

    // R9
    status_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ctl.load_bits |=> status[DATA_W-1:SR_LO] == $past(status[DATA_W-1:SR_LO]));

endmodule

// File: rtl/smem_cmd_fsm.sv
module smem_cmd_fsm
    import smem_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        frame_start,
    input  logic        frame_end,
    input  logic        rx_valid,
    input  logic [7:0]  rx_byte,
    input  logic        tx_req,
    input  logic        latch,
    input  logic        sr_wp,
    output phase_e      phase,
    output addr_ctl_t   actl,
    output sr_ctl_t     sctl,
    output logic        mem_we,
    output logic        wr_hit
);
    phase_e ph_nx;
    logic   is_read_q, is_read_nx;
    logic   hit_nx;

    always_comb begin
        ph_nx      = phase;
        is_read_nx = is_read_q;
        hit_nx     = wr_hit;
        actl       = '0;
        sctl       = '0;
        mem_we     = 1'b0;

        if (frame_end) begin
            ph_nx          = PH_IDLE;
            hit_nx         = 1'b0;
            sctl.clr_latch = wr_hit;
        end else if (frame_start) begin
            ph_nx  = PH_CMD;
            hit_nx = 1'b0;
        end else begin
            unique case (phase)
                PH_CMD: if (rx_valid) begin
                    ph_nx = PH_SKIP;
                    case (rx_byte)
                        CMD_LATCH_ON:  sctl.set_latch = 1'b1;
                        CMD_LATCH_OFF: sctl.clr_latch = 1'b1;
                        CMD_SR_READ:   ph_nx = PH_SR_OUT;
                        CMD_SR_WRITE:  if (latch) ph_nx = PH_SR_IN;
                        CMD_MEM_READ: begin
                            ph_nx      = PH_ADR_HI;
                            is_read_nx = 1'b1;
                        end
                        CMD_MEM_WRITE: if (latch) begin
                            ph_nx      = PH_ADR_HI;
                            is_read_nx = 1'b0;
                        end
                        default: ph_nx = PH_SKIP;
                    endcase
                end
                PH_ADR_HI: if (rx_valid) begin
                    actl.load_hi = 1'b1;
                    ph_nx        = PH_ADR_LO;
                end
                PH_ADR_LO: if (rx_valid) begin
                    actl.load_lo = 1'b1;
                    ph_nx        = is_read_q ? PH_RD_FETCH : PH_WR_DATA;
                end
                PH_WR_DATA: if (rx_valid) begin
                    mem_we    = 1'b1;
                    actl.step = 1'b1;
                    hit_nx    = 1'b1;
                end
                PH_RD_FETCH: ph_nx = PH_RD_CAPT;
                PH_RD_CAPT:  ph_nx = PH_RD_DATA;
                PH_RD_DATA: if (tx_req) begin
                    actl.step = 1'b1;
                    ph_nx     = PH_RD_FETCH;
                end
                PH_SR_IN: if (rx_valid) begin
                    ph_nx = PH_SKIP;
                    if (!sr_wp) begin
                        sctl.load_bits = 1'b1;
                        hit_nx         = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            is_read_q <= 1'b0;
            wr_hit    <= 1'b0;
        end else begin
            phase     <= ph_nx;
            is_read_q <= is_read_nx;
            wr_hit    <= hit_nx;
        end
    end

    // R12 R11
    skip_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        phase == PH_SKIP |-> !mem_we && !sctl.load_bits && !actl.step);

endmodule

// File: rtl/smem_cmd_ctrl.sv
module smem_cmd_ctrl
    import smem_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          frame_start,
    input  logic          frame_end,
    input  logic          rx_valid,
    input  logic [7:0]    rx_byte,
    input  logic          tx_req,
    output logic [7:0]    tx_byte,
    output logic          tx_en,
    input  logic          sr_wp,
    output logic [AW-1:0] ram_addr,
    output logic [7:0]    ram_wdata,
    output logic          ram_we,
    input  logic [7:0]    ram_rdata
);
    phase_e      phase;
    addr_ctl_t   actl;
    sr_ctl_t     sctl;
    logic        latch;
    logic        wr_hit;
    logic [7:0]  status;
    logic [7:0]  rd_buf;

    smem_cmd_fsm u_fsm (
        .clk(clk), .rst(rst),
        .frame_start(frame_start), .frame_end(frame_end),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_req(tx_req),
        .latch(latch), .sr_wp(sr_wp),
        .phase(phase), .actl(actl), .sctl(sctl),
        .mem_we(ram_we), .wr_hit(wr_hit)
    );

    smem_addr_ctr #(.AW(AW)) u_addr (
        .clk(clk), .rst(rst), .ctl(actl),
        .hi_in(rx_byte[AW-9:0]), .lo_in(rx_byte),
        .addr(ram_addr)
    );

    smem_status u_sr (
        .clk(clk), .rst(rst), .ctl(sctl),
        .wbits(rx_byte[7:SR_LO]),
        .latch(latch), .status(status)
    );

    always_ff @(posedge clk) begin
        if (rst)                     rd_buf <= '0;
        else if (phase == PH_RD_CAPT) rd_buf <= ram_rdata;
    end

    assign ram_wdata = rx_byte;
    assign tx_en     = is_tx_phase(phase);
    assign tx_byte   = (phase == PH_SR_OUT) ? status : rd_buf;

    // R3
    wel_gate_chk: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> latch);

    // R8
    wel_drop_chk: assert property (@(posedge clk) disable iff (rst)
        frame_end && wr_hit |=> !latch);

    // R13
    so_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !(tx_en && ram_we));

    // R2
    wren_set_chk: assert property (@(posedge clk) disable iff (rst)
        phase == PH_CMD && rx_valid && !frame_start && !frame_end
            && rx_byte == 8'h06 |=> latch);

endmodule

// File: tb/smem_cmd_ctrl_bench.sv
module smem_cmd_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_start = 1'b0, frame_end = 1'b0;
    logic        rx_valid = 1'b0, tx_req = 1'b0, sr_wp = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic [7:0]  tx_byte, ram_wdata, ram_rdata;
    logic        tx_en, ram_we;
    logic [14:0] ram_addr;

    int n_chk = 0, n_bad = 0, cyc = 0, we_cnt = 0, tx_seen = 0;
    logic [7:0] mem [int unsigned];

    always #10 clk = ~clk;

    smem_cmd_ctrl u_smem_cmd_ctrl (
        .clk(clk), .rst(rst), .frame_start(frame_start), .frame_end(frame_end),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_req(tx_req),
        .tx_byte(tx_byte), .tx_en(tx_en), .sr_wp(sr_wp),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_we(ram_we),
        .ram_rdata(ram_rdata)
    );

    always @(posedge clk) begin
        ram_rdata <= mem.exists(int'(ram_addr)) ? mem[int'(ram_addr)] : 8'h00;
        if (ram_we) begin
            mem[int'(ram_addr)] = ram_wdata;
            we_cnt++;
        end
        if (tx_en) tx_seen++;
    end

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: act=%0d cycles exp<=100000", cyc);
            report();
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: act=%02h exp=%02h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk); rx_valid = 1'b1; rx_byte = b;
        @(negedge clk); rx_valid = 1'b0;
    endtask

    task automatic fopen();
        @(negedge clk); frame_start = 1'b1;
        @(negedge clk); frame_start = 1'b0;
    endtask

    task automatic fclose();
        @(negedge clk); frame_end = 1'b1;
        @(negedge clk); frame_end = 1'b0;
    endtask

    task automatic cmd1(input logic [7:0] op);
        fopen(); send(op); fclose();
    endtask

    task automatic rdsr(output logic [7:0] v, output logic en);
        fopen(); send(8'h05);
        v = tx_byte; en = tx_en;
        fclose();
    endtask

    task automatic wr1(input logic [15:0] a, input logic [7:0] d);
        fopen(); send(8'h02); send(a[15:8]); send(a[7:0]); send(d); fclose();
    endtask

    task automatic rd1(input logic [15:0] a, output logic [7:0] d);
        fopen(); send(8'h03); send(a[15:8]); send(a[7:0]);
        repeat (3) @(negedge clk);
        d = tx_byte;
        fclose();
    endtask

    localparam logic [23:0] VEC [6] = '{
        24'h0000_5A, 24'h0001_C3, 24'h1234_7E,
        24'h7FFE_01, 24'h8005_99, 24'h4321_E7
    };

    initial begin
        logic [7:0] v;
        logic       en;
        int         we0, tx0;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 tx_en", {7'd0, tx_en}, 8'h00);
        rdsr(v, en);
        chk("R1 status", v, 8'h00);
        chk("R9 status tx_en", {7'd0, en}, 8'h01);

        // R4 R5 R6: table of writes read back at the masked address
        for (int i = 0; i < 6; i++) begin
            cmd1(8'h06);
            wr1(VEC[i][23:8], VEC[i][7:0]);
            rd1(VEC[i][23:8] & 16'h7FFF, v);
            chk("R4 R5 R6 table readback", v, VEC[i][7:0]);
        end

        // R2
        cmd1(8'h06); rdsr(v, en); chk("R2 latch set", v, 8'h02);
        cmd1(8'h04); rdsr(v, en); chk("R2 latch clear", v, 8'h00);

        // R3: write without the latch
        we0 = we_cnt;
        wr1(16'h1234, 8'h00);
        fopen(); send(8'h01); send(8'hFC); fclose();
        chk("R3 no ram_we", 8'(we_cnt - we0), 8'h00);
        rd1(16'h1234, v); chk("R3 ram unchanged", v, 8'h7E);
        rdsr(v, en); chk("R3 status unchanged", v, 8'h00);

        // R4 R5 R13: burst write, then burst read
        cmd1(8'h06);
        tx0 = tx_seen;
        fopen(); send(8'h02); send(8'h02); send(8'h00);
        send(8'h11); send(8'h22); send(8'h33); fclose();
        chk("R13 no tx_en in write", 8'(tx_seen - tx0), 8'h00);
        fopen(); send(8'h03); send(8'h02); send(8'h00);
        for (int k = 0; k < 3; k++) begin
            repeat (3) @(negedge clk);
            chk("R5 burst read", tx_byte, 8'h11 * 8'(k + 1));
            chk("R13 tx_en in read", {7'd0, tx_en}, 8'h01);
            tx_req = 1'b1; @(negedge clk); tx_req = 1'b0;
        end
        fclose();
        chk("R13 tx_en after frame", {7'd0, tx_en}, 8'h00);

        // R8: latch was cleared by the burst write frame
        rdsr(v, en); chk("R8 cleared after write", v, 8'h00);

        // R7 wrap
        cmd1(8'h06);
        fopen(); send(8'h02); send(8'h7F); send(8'hFF); send(8'hAA); send(8'hBB); fclose();
        rd1(16'h0000, v); chk("R7 wrap write", v, 8'hBB);
        fopen(); send(8'h03); send(8'h7F); send(8'hFF);
        repeat (3) @(negedge clk);
        chk("R7 read 7FFF", tx_byte, 8'hAA);
        tx_req = 1'b1; @(negedge clk); tx_req = 1'b0;
        repeat (3) @(negedge clk);
        chk("R7 read wrap", tx_byte, 8'hBB);
        fclose();

        // R8: write frame without data keeps the latch
        cmd1(8'h06);
        fopen(); send(8'h02); send(8'h00); send(8'h40); fclose();
        rdsr(v, en); chk("R8 no data keeps latch", v, 8'h02);

        // R9: status write
        fopen(); send(8'h01); send(8'hFF); fclose();
        rdsr(v, en); chk("R9 status bits", v, 8'hFC);
        cmd1(8'h06); rdsr(v, en); chk("R9 with latch", v, 8'hFE);

        // R10: protected status write
        sr_wp = 1'b1;
        fopen(); send(8'h01); send(8'h00); fclose();
        rdsr(v, en); chk("R10 protected", v, 8'hFE);
        sr_wp = 1'b0;
        fopen(); send(8'h01); send(8'h00); fclose();
        rdsr(v, en); chk("R9 bits cleared", v, 8'h00);

        // R11: second byte not decoded
        fopen(); send(8'h06); send(8'h04); fclose();
        rdsr(v, en); chk("R11 latch stays", v, 8'h02);
        fopen(); send(8'h04); send(8'h06); fclose();
        rdsr(v, en); chk("R11 latch stays clear", v, 8'h00);

        // R12: unknown command
        cmd1(8'h06);
        we0 = we_cnt; tx0 = tx_seen;
        fopen(); send(8'hAB); send(8'h02); send(8'h00); send(8'h10);
        send(8'h77); send(8'h05); fclose();
        chk("R12 no ram_we", 8'(we_cnt - we0), 8'h00);
        chk("R12 no tx_en", 8'(tx_seen - tx0), 8'h00);
        rd1(16'h0010, v); chk("R12 ram unchanged", v, 8'h00);
        rdsr(v, en); chk("R12 latch kept", v, 8'h02);

        report();
    end
endmodule